// File: doc/BRIEF.md
# Speculative Helper Thread Lifecycle Controller

This block sits beside the cores of a small chip multiprocessor that runs thread-level speculation (TLS). It watches the L2 misses of the thread that currently holds the most speculative position in the TLS order. When such a miss has a predictable loaded value and a small address-indexed confidence table trusts the prediction, the block asks for that thread to be cloned onto an idle core as a runahead helper. The helper only warms caches and predictors. It is shielded from squashes, it never squashes TLS threads, and its state is thrown away when it ends.

The controller keeps one record per parent core holding the helper's core number. It withdraws the helper with a one-cycle kill pulse when the parent stops being the most speculative thread, when either the parent or the helper finishes, or when the helper takes an exception. The confidence table is trained from outside with the outcome of each value prediction. The spawn, kill and squash-shield outputs drive the core control logic directly.

Top module: `spec_helper_ctrl`

## Requirements
- R1: On synchronous reset every helper record and every confidence counter clears. After reset `spawn_o`, `kill_o` and `suppress_o` are all zero, and no miss can spawn until its counter has been trained.
- R2: The confidence table has `CONF_ENTRIES` (default 64) `CONF_W`-bit counters, indexed by the low log2(`CONF_ENTRIES`) bits of an address. A training event with `train_hit_i`=1 raises the counter by one and saturates at all-ones. With `train_hit_i`=0 it clears the counter. The new value is seen from the next cycle on.
- R3: A spawn needs all of the following: `top_valid_i`=1, a miss on the core named by `top_core_i` with `miss_pred_i` set for that core, and a counter at that miss address reading at least `CONF_THRESH` (default 3). Misses on every other core are ignored.
- R4: A spawn needs a free core, meaning one with `tls_active_i`=0 and not hosting a helper. The lowest-numbered free core is chosen and reported on `spawn_core_o`, and `spawn_parent_o` equals `top_core_i`.
- R5: No spawn occurs while the most speculative core already has a live helper.
- R6: A live helper is killed in the cycle its parent is not the most speculative thread, whether `top_valid_i` is 0 or `top_core_i` names another core.
- R7: A live helper is killed in the cycle `finish_i` is set for its parent core or for its own core.
- R8: A live helper is killed in the cycle `exc_i` is set for its own core. An exception on any other core does not kill it.
- R9: Kills win. In a cycle in which any kill is pulsed, `spawn_o` stays low.
- R10: `suppress_o[c]` is high from the cycle after a spawn onto core c through the cycle of its kill, and low from the cycle after the kill. The core is free for a new spawn from that cycle.
- R11: `spawn_o` and each `kill_o` bit are single-cycle pulses. `kill_o[c]`, indexed by helper core, is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tls_active_i | input | NUM_CORES | Core runs a TLS thread |
| top_valid_i | input | 1 | A most speculative TLS thread exists |
| top_core_i | input | log2(NUM_CORES) | Core of the most speculative TLS thread |
| miss_valid_i | input | NUM_CORES | L2 miss event per core |
| miss_addr_i | input | NUM_CORES*ADDR_W | Miss address per core, core c in bits [c*ADDR_W +: ADDR_W] |
| miss_pred_i | input | NUM_CORES | Value of the missing load is predictable |
| train_valid_i | input | 1 | Prediction outcome available for training |
| train_addr_i | input | ADDR_W | Address of the trained prediction |
| train_hit_i | input | 1 | Prediction was correct |
| finish_i | input | NUM_CORES | Thread on the core finished |
| exc_i | input | NUM_CORES | Thread on the core raised an exception |
| spawn_o | output | 1 | Spawn request pulse |
| spawn_core_o | output | log2(NUM_CORES) | Core that receives the helper |
| spawn_parent_o | output | log2(NUM_CORES) | Core whose thread is cloned |
| kill_o | output | NUM_CORES | Kill pulse, indexed by helper core |
| suppress_o | output | NUM_CORES | Core hosts a helper: shield from squashes, discard state |

## Verification
The bench builds four cores, 64 two-bit counters with a threshold of 3, and 12-bit addresses. With these values the all-ones comparison variant of the table is selected. Addresses that differ only above bit 5 alias to the same counter, so one wrong prediction can be shown to reset the counter for a different address. With four cores, a parent, a second TLS thread and two idle cores coexist, so lowest-free selection, a freed core being reused, and a kill meeting a spawn attempt from a different parent in the same cycle can all be exercised. A long randomized phase then moves the speculative head around while misses, training, finishes and exceptions arrive together.

// File: rtl/spec_helper_pkg.sv
package spec_helper_pkg;

   // Saturating confidence update: +1 on a correct prediction, clear on a wrong one.
   function automatic logic [7:0] conf_step(input logic [7:0] cur,
                                            input logic       hit,
                                            input logic [7:0] max_val);
      if (!hit)
         return 8'd0;
      else if (cur >= max_val)
         return max_val;
      else
         return cur + 8'd1;
   endfunction

endpackage

// File: rtl/spec_conf_table.sv
module spec_conf_table #(
   parameter  int ENTRIES = 64,
   parameter  int CNT_W   = 2,
   parameter  int THRESH  = 3,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             confident_o,
   input  logic             train_valid_i,
   input  logic [IDX_W-1:0] train_idx_i,
   input  logic             train_hit_i
);
   import spec_helper_pkg::*;

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic [CNT_W-1:0] tbl [ENTRIES];

   initial begin
      assert (CNT_W >= 1 && CNT_W <= 8) else $error("counter width out of range");
      assert ((1 << IDX_W) == ENTRIES) else $error("entry count must be a power of two");
      assert (THRESH >= 1 && THRESH <= CNT_MAX) else $error("threshold not reachable");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      end else if (train_valid_i) begin
         tbl[train_idx_i] <= CNT_W'(conf_step(8'(tbl[train_idx_i]), train_hit_i, 8'(CNT_MAX)));
      end
   end

   generate
      if (THRESH == CNT_MAX) begin : g_thr_full
         assign confident_o = &tbl[rd_idx_i];
      end else begin : g_thr_cmp
         assign confident_o = (tbl[rd_idx_i] >= CNT_W'(THRESH));
      end
   endgenerate

   // R2
   train_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (train_valid_i && !train_hit_i) |=> (tbl[$past(train_idx_i)] == '0));

   // R2
   train_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (train_valid_i && train_hit_i && tbl[train_idx_i] == CNT_W'(CNT_MAX))
      |=> (tbl[$past(train_idx_i)] == CNT_W'(CNT_MAX)));

endmodule

// File: rtl/spec_free_pick.sv
module spec_free_pick #(
   parameter  int N    = 4,
   localparam int ID_W = $clog2(N)
) (
   input  logic [N-1:0]    free_i,
   output logic            any_o,
   output logic [ID_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int c = N - 1; c >= 0; c--) begin
         if (free_i[c]) idx_o = ID_W'(c);
      end
   end

   assign any_o = |free_i;

endmodule

// File: rtl/spec_helper_slot.sv
module spec_helper_slot #(
   parameter  int N    = 4,
   parameter  int SELF = 0,
   localparam int ID_W = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            top_valid_i,
   input  logic [ID_W-1:0] top_core_i,
   input  logic [N-1:0]    finish_i,
   input  logic [N-1:0]    exc_i,
   input  logic            set_i,
   input  logic [ID_W-1:0] set_core_i,
   output logic            valid_o,
   output logic [ID_W-1:0] helper_o,
   output logic            kill_o
);
   logic            valid_q;
   logic [ID_W-1:0] helper_q;
   logic            parent_is_top;

   assign parent_is_top = top_valid_i && (top_core_i == ID_W'(SELF));

   assign kill_o = valid_q && (!parent_is_top || finish_i[SELF] ||
                               finish_i[helper_q] || exc_i[helper_q]);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q  <= 1'b0;
         helper_q <= '0;
      end else if (kill_o) begin
         valid_q  <= 1'b0;
      end else if (set_i) begin
         valid_q  <= 1'b1;
         helper_q <= set_core_i;
      end
   end

   assign valid_o  = valid_q;
   assign helper_o = helper_q;

   // R10
   slot_release_chk: assert property (@(posedge clk) disable iff (rst)
      kill_o |=> !valid_o);

   // R10
   slot_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (set_i && !valid_o) |=> (valid_o && helper_o == $past(set_core_i)));

endmodule

// File: rtl/spec_helper_ctrl.sv
module spec_helper_ctrl #(
   parameter  int NUM_CORES    = 4,
   parameter  int ADDR_W       = 32,
   parameter  int CONF_ENTRIES = 64,
   parameter  int CONF_W       = 2,
   parameter  int CONF_THRESH  = 3,
   localparam int ID_W         = $clog2(NUM_CORES),
   localparam int IDX_W        = $clog2(CONF_ENTRIES)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_CORES-1:0]        tls_active_i,
   input  logic                        top_valid_i,
   input  logic [ID_W-1:0]             top_core_i,
   input  logic [NUM_CORES-1:0]        miss_valid_i,
   input  logic [NUM_CORES*ADDR_W-1:0] miss_addr_i,
   input  logic [NUM_CORES-1:0]        miss_pred_i,
   input  logic                        train_valid_i,
   input  logic [ADDR_W-1:0]           train_addr_i,
   input  logic                        train_hit_i,
   input  logic [NUM_CORES-1:0]        finish_i,
   input  logic [NUM_CORES-1:0]        exc_i,
   output logic                        spawn_o,
   output logic [ID_W-1:0]             spawn_core_o,
   output logic [ID_W-1:0]             spawn_parent_o,
   output logic [NUM_CORES-1:0]        kill_o,
   output logic [NUM_CORES-1:0]        suppress_o
);
   initial begin
      assert (NUM_CORES >= 2 && (1 << ID_W) == NUM_CORES)
         else $error("core count must be a power of two, at least 2");
      assert (ADDR_W >= IDX_W) else $error("address narrower than table index");
   end

   logic [ADDR_W-1:0]    top_addr;
   logic                 top_miss;
   logic                 confident;
   logic [NUM_CORES-1:0] free_cores;
   logic                 any_free;
   logic [ID_W-1:0]      pick_core;
   logic [NUM_CORES-1:0] slot_valid;
   logic [NUM_CORES-1:0] slot_kill;
   logic [ID_W-1:0]      slot_helper [NUM_CORES];
   logic                 unused_addr_bits;

   assign unused_addr_bits = ^{miss_addr_i, train_addr_i};

   assign top_addr = miss_addr_i[top_core_i*ADDR_W +: ADDR_W];
   assign top_miss = miss_valid_i[top_core_i] && miss_pred_i[top_core_i];

   spec_conf_table #(
      .ENTRIES (CONF_ENTRIES),
      .CNT_W   (CONF_W),
      .THRESH  (CONF_THRESH)
   ) i_conf (
      .clk           (clk),
      .rst           (rst),
      .rd_idx_i      (top_addr[IDX_W-1:0]),
      .confident_o   (confident),
      .train_valid_i (train_valid_i),
      .train_idx_i   (train_addr_i[IDX_W-1:0]),
      .train_hit_i   (train_hit_i)
   );

   assign free_cores = ~tls_active_i & ~suppress_o;

   spec_free_pick #(.N(NUM_CORES)) i_pick (
      .free_i (free_cores),
      .any_o  (any_free),
      .idx_o  (pick_core)
   );

   generate
      for (genvar p = 0; p < NUM_CORES; p++) begin : g_slot
         spec_helper_slot #(.N(NUM_CORES), .SELF(p)) i_slot (
            .clk         (clk),
            .rst         (rst),
            .top_valid_i (top_valid_i),
            .top_core_i  (top_core_i),
            .finish_i    (finish_i),
            .exc_i       (exc_i),
            .set_i       (spawn_o && (top_core_i == ID_W'(p))),
            .set_core_i  (pick_core),
            .valid_o     (slot_valid[p]),
            .helper_o    (slot_helper[p]),
            .kill_o      (slot_kill[p])
         );
      end
   endgenerate

   // Fold the per-parent records onto helper-core-indexed vectors.
   always_comb begin
      kill_o     = '0;
      suppress_o = '0;
      for (int p = 0; p < NUM_CORES; p++) begin
         if (slot_kill[p])  kill_o[slot_helper[p]]     = 1'b1;
         if (slot_valid[p]) suppress_o[slot_helper[p]] = 1'b1;
      end
   end

   assign spawn_o = top_valid_i && top_miss && confident && any_free &&
                    !slot_valid[top_core_i] && !(|slot_kill);
   assign spawn_core_o   = pick_core;
   assign spawn_parent_o = top_core_i;

   // R4
   spawn_target_free_chk: assert property (@(posedge clk) disable iff (rst)
      spawn_o |-> (!tls_active_i[spawn_core_o] && !suppress_o[spawn_core_o]));

   // R9
   kill_beats_spawn_chk: assert property (@(posedge clk) disable iff (rst)
      (|kill_o) |-> !spawn_o);

   // R10
   spawn_shield_chk: assert property (@(posedge clk) disable iff (rst)
      spawn_o |=> suppress_o[$past(spawn_core_o)]);

   // R11
   kill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (|kill_o) |=> ((kill_o & $past(kill_o)) == '0));

   // R5
   one_helper_chk: assert property (@(posedge clk) disable iff (rst)
      spawn_o |=> (!spawn_o || spawn_parent_o != $past(spawn_parent_o)));

endmodule

// File: tb/test_spec_helper_ctrl.sv
module test_spec_helper_ctrl;
   localparam int N   = 4;
   localparam int AW  = 12;
   localparam int ENT = 64;
   localparam int CW  = 2;
   localparam int TH  = 3;
   localparam int IW  = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic [N-1:0]  tls_active;
   logic          top_valid;
   logic [IW-1:0] top_core;
   logic [N-1:0]  miss_valid;
   logic [N*AW-1:0] miss_addr;
   logic [N-1:0]  miss_pred;
   logic          train_valid;
   logic [AW-1:0] train_addr;
   logic          train_hit;
   logic [N-1:0]  finish;
   logic [N-1:0]  exc;
   logic          spawn;
   logic [IW-1:0] spawn_core;
   logic [IW-1:0] spawn_parent;
   logic [N-1:0]  kill;
   logic [N-1:0]  suppress;

   always #5 clk = ~clk;

   spec_helper_ctrl #(
      .NUM_CORES(N), .ADDR_W(AW), .CONF_ENTRIES(ENT), .CONF_W(CW), .CONF_THRESH(TH)
   ) i_spec_helper_ctrl (
      .clk(clk), .rst(rst), .tls_active_i(tls_active), .top_valid_i(top_valid),
      .top_core_i(top_core), .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
      .miss_pred_i(miss_pred), .train_valid_i(train_valid), .train_addr_i(train_addr),
      .train_hit_i(train_hit), .finish_i(finish), .exc_i(exc), .spawn_o(spawn),
      .spawn_core_o(spawn_core), .spawn_parent_o(spawn_parent), .kill_o(kill),
      .suppress_o(suppress)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   string cur_req = "R1";

   // Behavioural reference state
   int m_conf [ENT];
   bit m_rv   [N];
   int m_rh   [N];

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic quiet();
      miss_valid  = '0;
      miss_pred   = '0;
      miss_addr   = '0;
      train_valid = 1'b0;
      train_addr  = '0;
      train_hit   = 1'b0;
      finish      = '0;
      exc         = '0;
   endtask

   task automatic set_miss(input int c, input int addr, input bit pred);
      miss_valid[c]          = 1'b1;
      miss_pred[c]           = pred;
      miss_addr[c*AW +: AW]  = AW'(addr);
   endtask

   task automatic set_train(input int addr, input bit hit);
      train_valid = 1'b1;
      train_addr  = AW'(addr);
      train_hit   = hit;
   endtask

   // Evaluate the model against the outputs, advance the model, wait for the next drive point.
   task automatic tick();
      logic [N-1:0] ek, eh;
      bit           es;
      int           ec, tc, ai;
      bit           kp [N];
      #2;
      ek = '0; eh = '0; es = 1'b0; ec = 0; tc = int'(top_core);
      for (int p = 0; p < N; p++) begin
         kp[p] = 1'b0;
         if (m_rv[p]) begin
            int h = m_rh[p];
            bit ist = top_valid && (tc == p);
            eh[h] = 1'b1;
            if (!ist || finish[p] || finish[h] || exc[h]) begin
               ek[h] = 1'b1;
               kp[p] = 1'b1;
            end
         end
      end
      ai = int'(miss_addr[tc*AW +: AW]) % ENT;
      if (ek == '0 && top_valid && !m_rv[tc] && miss_valid[tc] && miss_pred[tc] && m_conf[ai] >= TH) begin
         for (int c = 0; c < N; c++) begin
            if (!es && !tls_active[c] && !eh[c]) begin
               es = 1'b1;
               ec = c;
            end
         end
      end
      chk(cur_req, "suppress", int'(suppress), int'(eh));
      chk(cur_req, "kill", int'(kill), int'(ek));
      chk(cur_req, "spawn", int'(spawn), int'(es));
      if (es) begin
         chk(cur_req, "spawn_core", int'(spawn_core), ec);
         chk(cur_req, "spawn_parent", int'(spawn_parent), tc);
      end
      for (int p = 0; p < N; p++) if (kp[p]) m_rv[p] = 1'b0;
      if (es) begin
         m_rv[tc] = 1'b1;
         m_rh[tc] = ec;
      end
      if (train_valid) begin
         int ti = int'(train_addr) % ENT;
         if (!train_hit) m_conf[ti] = 0;
         else if (m_conf[ti] < 3) m_conf[ti] = m_conf[ti] + 1;
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < ENT; i++) m_conf[i] = 0;
      for (int p = 0; p < N; p++) begin m_rv[p] = 1'b0; m_rh[p] = 0; end
      quiet();
      rst = 1'b1; tls_active = 4'b0011; top_valid = 1'b1; top_core = 2'd1;
      repeat (3) @(negedge clk);
      // R1 outputs idle during reset
      chk("R1", "kill in reset", int'(kill), 0);
      chk("R1", "suppress in reset", int'(suppress), 0);
      rst = 1'b0;

      // R1: untrained counter blocks spawn after reset
      cur_req = "R1"; quiet(); set_miss(1, 'h005, 1); tick();

      // R2: training, aliasing clear, saturation
      cur_req = "R2";
      quiet(); set_train('h005, 1); tick();
      quiet(); set_train('h005, 1); tick();
      quiet(); set_miss(1, 'h005, 1); tick();           // count 2: no spawn
      quiet(); set_train('h045, 0); tick();             // alias of index 5 clears it
      quiet(); set_miss(1, 'h005, 1); set_train('h005, 1); tick(); // old value 0 read
      quiet(); set_train('h005, 1); tick();
      quiet(); set_train('h005, 1); tick();
      quiet(); set_train('h005, 1); tick();             // saturate at 3

      // R3: gating conditions
      cur_req = "R3";
      quiet(); set_miss(0, 'h005, 1); tick();           // non-top core ignored
      quiet(); set_miss(1, 'h005, 0); tick();           // not predictable
      quiet(); set_miss(1, 'h006, 1); tick();           // untrained entry
      quiet(); top_valid = 1'b0; set_miss(1, 'h005, 1); tick();
      top_valid = 1'b1;

      // R4: spawn onto lowest free core (2), parent 1
      cur_req = "R4"; quiet(); set_miss(1, 'h105, 1); tick();
      // R10: shield held
      cur_req = "R10"; quiet(); tick();
      // R5: second helper for same parent refused
      cur_req = "R5"; quiet(); set_miss(1, 'h005, 1); tick();
      // R6: top invalid kills
      cur_req = "R6"; quiet(); top_valid = 1'b0; tick();
      cur_req = "R11"; quiet(); top_valid = 1'b1; tick();

      // R9: kill of parent 1 helper while parent 0 becomes head and misses
      cur_req = "R9"; quiet(); set_miss(1, 'h005, 1); tick();  // respawn on 2
      quiet(); top_core = 2'd0; set_miss(0, 'h005, 1); tick(); // kill, spawn held
      cur_req = "R10"; quiet(); set_miss(0, 'h005, 1); tick(); // core 2 free again

      // R7: helper finish, then parent finish
      cur_req = "R7"; quiet(); finish[2] = 1'b1; tick();
      quiet(); set_miss(0, 'h005, 1); tick();
      quiet(); finish[0] = 1'b1; tick();

      // R8: exception on other core ignored, on helper kills
      cur_req = "R8"; quiet(); set_miss(0, 'h005, 1); tick();
      quiet(); exc[1] = 1'b1; tick();
      quiet(); exc[0] = 1'b1; tick();
      quiet(); exc[2] = 1'b1; tick();

      // R4: lowest free among {1,3}
      cur_req = "R4"; quiet(); tls_active = 4'b0101; set_miss(0, 'h005, 1); tick();
      quiet(); top_core = 2'd2; tick();

      // Randomized mix
      cur_req = "R3";
      for (int k = 0; k < 3000; k++) begin
         quiet();
         if (($urandom % 8) == 0) top_core = IW'($urandom);
         top_valid  = (($urandom % 10) != 0);
         tls_active = N'($urandom) | (N'(1) << top_core);
         for (int c = 0; c < N; c++) begin
            if (($urandom % 3) == 0)
               set_miss(c, int'(($urandom % 4) * 64 + ($urandom % 4)), ($urandom % 4) != 0);
         end
         if (($urandom % 2) == 0) set_train(int'($urandom % 4), ($urandom % 5) != 0);
         for (int c = 0; c < N; c++) begin
            finish[c] = (($urandom % 20) == 0);
            exc[c]    = (($urandom % 25) == 0);
         end
         tick();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule